// File: doc/BRIEF.md
# I2C Register Access Gate

This block sits behind a byte-level I2C slave front end. The front end resolves the bit timing on SCL and SDA and hands over four kinds of event: a START, a received byte, a request for the next byte of a read, and a STOP. The gate treats the first byte after a START as the address byte. It matches that byte against three device identifiers: the memory array, the control-register space and an auxiliary space. It then decides the ACK or NACK for every byte and keeps one shared register address pointer. Write data bytes and read requests are passed on to the storage, tagged with the device and the pointer value.

A write to the command register goes out on its own strobe instead of the ordinary write port. That register is at address 0xAA of the control device. A write-protect input blocks every write and also holds the pointer still. The gate also works with a nonvolatile sequencer. While the sequencer reports busy, address bytes get a NACK, so the master can poll for readiness. A sleep request starts an entry window in which nothing is acknowledged, and the gate then goes to sleep. A matching address received during sleep starts a wake window, and normal access comes back when that window ends.

Top module: `i2c_reg_gate`

## Requirements
- R1: After reset all strobes (`ack_vld`, `wr_en`, `cmd_vld`, `rd_en`) and `pwr_down` are low and the register pointer is 0.
- R2: An address byte whose upper seven bits equal `MEM_ID`, `CTRL_ID` or `AUX_ID` gets an ACK (`ack_vld` and `ack` high in the cycle after the byte event). Bit 0 of the address byte is R/W, with 0 meaning write. The device code is 1 for memory, 2 for control and 3 for auxiliary.
- R3: An address byte that matches no identifier gets a NACK. Every later byte of that transaction also gets a NACK, and the pointer and power state do not change.
- R4: In a write transaction the first byte after the address loads the pointer and gets an ACK. Each following byte gets an ACK and appears on `wr_en`/`wr_dev`/`wr_addr`/`wr_data` one cycle later, with `wr_addr` equal to the pointer.
- R5: Each byte that is written or read advances the pointer by one. The pointer wraps from 2^AW-1 to 0.
- R6: A data byte written to the control device while the pointer equals `CMD_ADDR` (0xAA) raises `cmd_vld` with `cmd_data` instead of `wr_en`.
- R7: A data byte that arrives with `wp` high gets an ACK, but it raises neither `wr_en` nor `cmd_vld` and it leaves the pointer unchanged.
- R8: In a read transaction each `ev_rd_req` raises `rd_en` one cycle later, with `rd_addr` equal to the pointer and `rd_dev` equal to the device code.
- R9: While `nv_busy` is high a matching address byte gets a NACK. Once `nv_busy` is low the same byte gets an ACK.
- R10: After a `sleep_req` pulse, every byte gets a NACK for `SLEEP_CYC` cycles. `pwr_down` then rises exactly `SLEEP_CYC` cycles after the cycle in which the request was taken.
- R11: While asleep, a non-matching address gets a NACK and does not wake the gate. A matching address gets a NACK, lowers `pwr_down` and starts a `WAKE_CYC`-cycle window in which bytes still get a NACK. The first address byte after that window gets an ACK.
- R12: A byte that arrives in the same cycle as `sleep_req` gets a NACK and is not written.
- R13: A byte received outside a transaction (no START yet, or after a STOP) gets a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | START condition seen |
| ev_stop | input | 1 | STOP condition seen |
| ev_byte | input | 1 | A byte was received from the master |
| byte_data | input | 8 | The received byte |
| ev_rd_req | input | 1 | Front end needs the next read byte |
| wp | input | 1 | Write protect, active high |
| nv_busy | input | 1 | Nonvolatile sequencer busy |
| sleep_req | input | 1 | Sleep request pulse from the sequencer |
| ack_vld | output | 1 | Response valid for the previous byte |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| wr_en | output | 1 | Write strobe |
| wr_dev | output | 2 | Device code of the write |
| wr_addr | output | AW | Register address of the write |
| wr_data | output | 8 | Write data |
| cmd_vld | output | 1 | Command register strobe |
| cmd_data | output | 8 | Command byte |
| rd_en | output | 1 | Read fetch strobe |
| rd_dev | output | 2 | Device code of the read |
| rd_addr | output | AW | Register address of the read |
| pwr_down | output | 1 | Gate is asleep |

## Verification
A sleep request from the sequencer can arrive in the same cycle as a byte from the master. The bench provokes this in the middle of a write: it drives `sleep_req` together with a data byte. The result is judged at the ports: the response must be a NACK with no write strobe. After the full sleep, wake and wake window, a read must show the pointer still at the address that was loaded. A second overlap is a data byte arriving while write protect is high. For that byte the bench checks that an ACK is still given, that no write goes out, and that the next unprotected byte lands at the same address.

// File: rtl/i2c_gate_pkg.sv
package i2c_gate_pkg;

    typedef enum logic [1:0] {
        DEV_NONE = 2'd0,
        DEV_MEM  = 2'd1,
        DEV_CTRL = 2'd2,
        DEV_AUX  = 2'd3
    } dev_e;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_REGA,
        XS_WDATA,
        XS_RDATA,
        XS_IGNORE
    } xact_e;

    typedef enum logic [1:0] {
        PS_AWAKE,
        PS_ENTER,
        PS_ASLEEP,
        PS_WAKING
    } pwr_e;

    typedef struct packed {
        logic vld;
        logic ack;
    } resp_t;

    // Fixed priority: memory, then control, then auxiliary.
    function automatic dev_e match_dev(input logic [6:0] a,
                                       input logic [6:0] mem_id,
                                       input logic [6:0] ctrl_id,
                                       input logic [6:0] aux_id);
        if (a == mem_id)       return DEV_MEM;
        else if (a == ctrl_id) return DEV_CTRL;
        else if (a == aux_id)  return DEV_AUX;
        else                   return DEV_NONE;
    endfunction

endpackage

// File: rtl/i2c_gate_pwr.sv
module i2c_gate_pwr
    import i2c_gate_pkg::*;
#(
    parameter int SLEEP_CYC = 20,
    parameter int WAKE_CYC  = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_hit,
    output logic gate_open,
    output logic asleep
);
    localparam int MAXC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pwr_e          st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_AWAKE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                PS_AWAKE: begin
                    if (sleep_req) begin
                        st_q  <= PS_ENTER;
                        cnt_q <= CW'(SLEEP_CYC - 1);
                    end
                end
                PS_ENTER: begin
                    if (cnt_q == '0) st_q <= PS_ASLEEP;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                PS_ASLEEP: begin
                    if (wake_hit) begin
                        st_q  <= PS_WAKING;
                        cnt_q <= CW'(WAKE_CYC - 1);
                    end
                end
                default: begin
                    if (cnt_q == '0) st_q <= PS_AWAKE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    // A request arriving this cycle already closes the gate.
    assign gate_open = (st_q == PS_AWAKE) && !sleep_req;
    assign asleep    = (st_q == PS_ASLEEP);

endmodule

// File: rtl/i2c_gate_ptr.sv
module i2c_gate_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;   // natural wrap at 2^AW
    end
endmodule

// File: rtl/i2c_gate_xact.sv
module i2c_gate_xact
    import i2c_gate_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [AW-1:0] CMD_ADDR = AW'('hAA),
    parameter logic [6:0]  MEM_ID   = 7'h50,
    parameter logic [6:0]  CTRL_ID  = 7'h18,
    parameter logic [6:0]  AUX_ID   = 7'h58
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_byte,
    input  logic [7:0]    byte_data,
    input  logic          ev_rd_req,
    input  logic          wp,
    input  logic          nv_busy,
    input  logic          gate_open,
    input  logic          asleep,
    input  logic [AW-1:0] ptr,
    output logic          ptr_load,
    output logic          ptr_inc,
    output logic          wake_hit,
    output logic          in_wdata,
    output logic          ack_vld,
    output logic          ack,
    output logic          wr_en,
    output logic [1:0]    wr_dev,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          cmd_vld,
    output logic [7:0]    cmd_data,
    output logic          rd_en,
    output logic [1:0]    rd_dev,
    output logic [AW-1:0] rd_addr
);
    xact_e xs_q, xs_n;
    dev_e  dev_q, dev_n, hit;
    resp_t resp_n;
    logic  wr_n, cmd_n, rd_n;

    assign hit      = match_dev(byte_data[7:1], MEM_ID, CTRL_ID, AUX_ID);
    assign in_wdata = (xs_q == XS_WDATA);

    always_comb begin
        xs_n     = xs_q;
        dev_n    = dev_q;
        resp_n   = '0;
        wr_n     = 1'b0;
        cmd_n    = 1'b0;
        rd_n     = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        wake_hit = 1'b0;
        if (ev_start) begin
            xs_n = XS_ADDR;
        end else if (ev_stop) begin
            xs_n = XS_IDLE;
        end else if (ev_byte) begin
            resp_n.vld = 1'b1;
            case (xs_q)
                XS_ADDR: begin
                    xs_n = XS_IGNORE;
                    if (hit != DEV_NONE) begin
                        if (asleep) begin
                            wake_hit = 1'b1;
                        end else if (gate_open && !nv_busy) begin
                            resp_n.ack = 1'b1;
                            dev_n      = hit;
                            xs_n       = byte_data[0] ? XS_RDATA : XS_REGA;
                        end
                    end
                end
                XS_REGA: begin
                    xs_n = XS_IGNORE;
                    if (gate_open) begin
                        resp_n.ack = 1'b1;
                        ptr_load   = 1'b1;
                        xs_n       = XS_WDATA;
                    end
                end
                XS_WDATA: begin
                    if (gate_open) begin
                        resp_n.ack = 1'b1;
                        if (!wp) begin
                            ptr_inc = 1'b1;
                            if (dev_q == DEV_CTRL && ptr == CMD_ADDR) cmd_n = 1'b1;
                            else                                      wr_n  = 1'b1;
                        end
                    end else begin
                        xs_n = XS_IGNORE;
                    end
                end
                default: xs_n = XS_IGNORE;
            endcase
        end else if (ev_rd_req && xs_q == XS_RDATA && gate_open) begin
            rd_n    = 1'b1;
            ptr_inc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xs_q     <= XS_IDLE;
            dev_q    <= DEV_NONE;
            ack_vld  <= 1'b0;
            ack      <= 1'b0;
            wr_en    <= 1'b0;
            wr_dev   <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
            cmd_vld  <= 1'b0;
            cmd_data <= '0;
            rd_en    <= 1'b0;
            rd_dev   <= '0;
            rd_addr  <= '0;
        end else begin
            xs_q    <= xs_n;
            dev_q   <= dev_n;
            ack_vld <= resp_n.vld;
            ack     <= resp_n.ack;
            wr_en   <= wr_n;
            cmd_vld <= cmd_n;
            rd_en   <= rd_n;
            if (wr_n) begin
                wr_dev  <= dev_q;
                wr_addr <= ptr;
                wr_data <= byte_data;
            end
            if (cmd_n) cmd_data <= byte_data;
            if (rd_n) begin
                rd_dev  <= dev_q;
                rd_addr <= ptr;
            end
        end
    end

endmodule

// File: rtl/i2c_reg_gate.sv
module i2c_reg_gate
    import i2c_gate_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] CMD_ADDR  = AW'('hAA),
    parameter logic [6:0]    MEM_ID    = 7'h50,
    parameter logic [6:0]    CTRL_ID   = 7'h18,
    parameter logic [6:0]    AUX_ID    = 7'h58,
    parameter int            SLEEP_CYC = 20,
    parameter int            WAKE_CYC  = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_byte,
    input  logic [7:0]    byte_data,
    input  logic          ev_rd_req,
    input  logic          wp,
    input  logic          nv_busy,
    input  logic          sleep_req,
    output logic          ack_vld,
    output logic          ack,
    output logic          wr_en,
    output logic [1:0]    wr_dev,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          cmd_vld,
    output logic [7:0]    cmd_data,
    output logic          rd_en,
    output logic [1:0]    rd_dev,
    output logic [AW-1:0] rd_addr,
    output logic          pwr_down
);
    logic          gate_open, asleep, wake_hit;
    logic          ptr_load, ptr_inc, in_wdata;
    logic [AW-1:0] ptr_q;

    i2c_gate_pwr #(
        .SLEEP_CYC (SLEEP_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_pwr (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .wake_hit  (wake_hit),
        .gate_open (gate_open),
        .asleep    (asleep)
    );

    i2c_gate_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (byte_data[AW-1:0]),
        .inc      (ptr_inc),
        .ptr      (ptr_q)
    );

    i2c_gate_xact #(
        .AW       (AW),
        .CMD_ADDR (CMD_ADDR),
        .MEM_ID   (MEM_ID),
        .CTRL_ID  (CTRL_ID),
        .AUX_ID   (AUX_ID)
    ) u_xact (
        .clk       (clk),
        .rst       (rst),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_byte   (ev_byte),
        .byte_data (byte_data),
        .ev_rd_req (ev_rd_req),
        .wp        (wp),
        .nv_busy   (nv_busy),
        .gate_open (gate_open),
        .asleep    (asleep),
        .ptr       (ptr_q),
        .ptr_load  (ptr_load),
        .ptr_inc   (ptr_inc),
        .wake_hit  (wake_hit),
        .in_wdata  (in_wdata),
        .ack_vld   (ack_vld),
        .ack       (ack),
        .wr_en     (wr_en),
        .wr_dev    (wr_dev),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmd_vld   (cmd_vld),
        .cmd_data  (cmd_data),
        .rd_en     (rd_en),
        .rd_dev    (rd_dev),
        .rd_addr   (rd_addr)
    );

    assign pwr_down = asleep;

endmodule

// File: rtl/i2c_reg_gate_chk.sv
module i2c_reg_gate_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_byte,
    input logic          wp,
    input logic          sleep_req,
    input logic          pwr_down,
    input logic          ack_vld,
    input logic          ack,
    input logic          wr_en,
    input logic          cmd_vld,
    input logic          rd_en,
    input logic          in_wdata,
    input logic [AW-1:0] ptr_q
);
    // R2: every response answers a byte from the previous cycle
    assert_resp_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> $past(ev_byte));

    // R7: no write or command strobe for a protected byte
    assert_wp_blocks_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en || cmd_vld) |-> !$past(wp));

    // R7: a protected data byte leaves the pointer where it was
    assert_wp_freezes_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (in_wdata && ev_byte && wp) |=> $stable(ptr_q));

    // R5: each forwarded byte moves the pointer by one
    assert_ptr_steps_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en || cmd_vld || rd_en) |-> (ptr_q == $past(ptr_q) + 1'b1));

    // R6: one kind of transfer per cycle
    assert_one_transfer_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, cmd_vld, rd_en}));

    // R10: nothing is acknowledged while asleep
    assert_no_ack_asleep_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && ack) |-> !$past(pwr_down));

    // R12: a byte that meets a sleep request is refused
    assert_sleep_collision_R12: assert property (@(posedge clk) disable iff (rst)
        (ev_byte && sleep_req) |=> (!ack && !wr_en && !cmd_vld));

endmodule

bind i2c_reg_gate i2c_reg_gate_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_byte   (ev_byte),
    .wp        (wp),
    .sleep_req (sleep_req),
    .pwr_down  (pwr_down),
    .ack_vld   (ack_vld),
    .ack       (ack),
    .wr_en     (wr_en),
    .cmd_vld   (cmd_vld),
    .rd_en     (rd_en),
    .in_wdata  (in_wdata),
    .ptr_q     (ptr_q)
);

// File: tb/sim_i2c_reg_gate.sv
`timescale 1ns/1ps
module sim_i2c_reg_gate;
    localparam int         AW    = 8;
    localparam logic [6:0] MEM   = 7'h50;
    localparam logic [6:0] CTRL  = 7'h18;
    localparam logic [6:0] AUX   = 7'h58;
    localparam int         SLP   = 6;
    localparam int         WAK   = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_rd_req = 0;
    logic [7:0] byte_data = 0;
    logic wp = 0, nv_busy = 0, sleep_req = 0;
    logic ack_vld, ack, wr_en, cmd_vld, rd_en, pwr_down;
    logic [1:0] wr_dev, rd_dev;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, cmd_data;

    int checks = 0, failures = 0;
    bit done = 0;

    // captured at the negedge after each event
    logic s_ackv, s_ack, s_wr, s_cmd, s_rd;
    logic [1:0] s_wdev, s_rdev;
    logic [7:0] s_waddr, s_wdata, s_cmdd, s_raddr;

    always #2.5 clk = ~clk;

    i2c_reg_gate #(
        .AW(AW), .CMD_ADDR(8'hAA), .MEM_ID(MEM), .CTRL_ID(CTRL), .AUX_ID(AUX),
        .SLEEP_CYC(SLP), .WAKE_CYC(WAK)
    ) u0 (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .byte_data(byte_data), .ev_rd_req(ev_rd_req),
        .wp(wp), .nv_busy(nv_busy), .sleep_req(sleep_req),
        .ack_vld(ack_vld), .ack(ack), .wr_en(wr_en), .wr_dev(wr_dev),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd_vld(cmd_vld),
        .cmd_data(cmd_data), .rd_en(rd_en), .rd_dev(rd_dev),
        .rd_addr(rd_addr), .pwr_down(pwr_down)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic capture();
        s_ackv = ack_vld; s_ack = ack; s_wr = wr_en; s_cmd = cmd_vld; s_rd = rd_en;
        s_wdev = wr_dev; s_waddr = wr_addr; s_wdata = wr_data; s_cmdd = cmd_data;
        s_rdev = rd_dev; s_raddr = rd_addr;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_start();
        ev_start = 1; step(); ev_start = 0;
    endtask

    task automatic do_stop();
        ev_stop = 1; step(); ev_stop = 0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        byte_data = b; ev_byte = 1; step(); ev_byte = 0; capture();
    endtask

    task automatic do_rd();
        ev_rd_req = 1; step(); ev_rd_req = 0; capture();
    endtask

    // open a read on a device and return the pointer through rd_addr
    task automatic read_ptr(input logic [6:0] dev, output logic [7:0] p);
        do_start(); do_byte({dev, 1'b1}); do_rd(); p = s_raddr; do_stop();
    endtask

    task automatic t_reset();
        logic [7:0] p;
        check("R1 ack_vld", ack_vld, 0); check("R1 wr_en", wr_en, 0);
        check("R1 cmd_vld", cmd_vld, 0); check("R1 rd_en", rd_en, 0);
        check("R1 pwr_down", pwr_down, 0);
        read_ptr(MEM, p);
        check("R1 pointer", p, 8'h00);
    endtask

    task automatic t_write();
        do_start();
        do_byte({MEM, 1'b0}); check("R2 addr ackv", s_ackv, 1); check("R2 addr ack", s_ack, 1);
        do_byte(8'h10);       check("R4 regaddr ack", s_ack, 1);
        do_byte(8'h5A);
        check("R4 wr_en", s_wr, 1); check("R4 wr_dev", s_wdev, 1);
        check("R4 wr_addr", s_waddr, 8'h10); check("R4 wr_data", s_wdata, 8'h5A);
        do_byte(8'h33);
        check("R5 inc addr", s_waddr, 8'h11); check("R5 inc data", s_wdata, 8'h33);
        do_stop();
    endtask

    task automatic t_wrap();
        do_start(); do_byte({AUX, 1'b0}); do_byte(8'hFF);
        do_byte(8'h01); check("R5 top addr", s_waddr, 8'hFF); check("R2 aux dev", s_wdev, 3);
        do_byte(8'h02); check("R5 wrap addr", s_waddr, 8'h00);
        do_stop();
    endtask

    task automatic t_cmd();
        do_start(); do_byte({CTRL, 1'b0}); check("R2 ctrl ack", s_ack, 1);
        do_byte(8'hAA);
        do_byte(8'h3C);
        check("R6 cmd_vld", s_cmd, 1); check("R6 cmd_data", s_cmdd, 8'h3C);
        check("R6 no wr_en", s_wr, 0);
        do_byte(8'h77);
        check("R6 after cmd wr", s_wr, 1); check("R6 after cmd addr", s_waddr, 8'hAB);
        do_stop();
        do_start(); do_byte({MEM, 1'b0}); do_byte(8'hAA); do_byte(8'h3C);
        check("R6 mem at AA is write", s_wr, 1); check("R6 mem at AA no cmd", s_cmd, 0);
        do_stop();
    endtask

    task automatic t_wp();
        logic [7:0] p;
        do_start(); do_byte({MEM, 1'b0}); do_byte(8'h20);
        wp = 1; do_byte(8'h11);
        check("R7 protected ack", s_ack, 1); check("R7 no write", s_wr, 0);
        wp = 0; do_byte(8'h22);
        check("R7 ptr frozen", s_waddr, 8'h20); check("R7 data", s_wdata, 8'h22);
        wp = 1; do_byte(8'h33); wp = 0;
        do_stop();
        read_ptr(MEM, p);
        check("R7 ptr after protected", p, 8'h21);
        do_start(); do_byte({CTRL, 1'b0}); do_byte(8'hAA);
        wp = 1; do_byte(8'h3C); wp = 0;
        check("R7 no cmd", s_cmd, 0);
        do_stop();
    endtask

    task automatic t_read();
        do_start(); do_byte({AUX, 1'b0}); do_byte(8'h40);
        do_start(); do_byte({AUX, 1'b1}); check("R8 read addr ack", s_ack, 1);
        do_rd(); check("R8 rd_en", s_rd, 1); check("R8 rd_addr", s_raddr, 8'h40);
        check("R8 rd_dev", s_rdev, 3);
        do_rd(); check("R8 rd_addr inc", s_raddr, 8'h41);
        do_stop();
    endtask

    task automatic t_badaddr();
        logic [7:0] p0, p1;
        read_ptr(MEM, p0);
        do_start(); do_byte({7'h77, 1'b0});
        check("R3 nack ackv", s_ackv, 1); check("R3 nack", s_ack, 0);
        do_byte(8'h05); check("R3 later nack", s_ack, 0);
        do_byte(8'h06); check("R3 no write", s_wr, 0);
        do_stop();
        check("R3 awake", pwr_down, 0);
        read_ptr(MEM, p1);
        check("R3 ptr kept", p1, p0 + 8'h01);
        do_byte({MEM, 1'b0}); check("R13 no start nack", s_ack, 0);
        check("R13 ackv", s_ackv, 1);
    endtask

    task automatic t_busy();
        nv_busy = 1;
        do_start(); do_byte({MEM, 1'b0}); check("R9 busy nack", s_ack, 0);
        do_stop();
        nv_busy = 0;
        do_start(); do_byte({MEM, 1'b0}); check("R9 ready ack", s_ack, 1);
        do_stop();
    endtask

    task automatic t_sleep();
        sleep_req = 1; step(); sleep_req = 0;            // edge 0
        do_start(); do_byte({MEM, 1'b0});                // edges 1, 2
        check("R10 entry nack", s_ack, 0);
        for (int k = 3; k < SLP; k++) step();
        check("R10 not yet asleep", pwr_down, 0);
        step();
        check("R10 asleep", pwr_down, 1);
        do_start(); do_byte({7'h77, 1'b0});
        check("R11 bad addr nack", s_ack, 0);
        step(); check("R11 stays asleep", pwr_down, 1);
        do_start(); do_byte({CTRL, 1'b0});               // wake edge 0
        check("R11 wake addr nack", s_ack, 0); check("R11 woke", pwr_down, 0);
        do_start(); do_byte({MEM, 1'b0});                // edges 1, 2
        check("R11 wake window nack", s_ack, 0);
        for (int k = 3; k <= WAK - 2; k++) step();
        do_start(); do_byte({MEM, 1'b0});                // edges W-1, W
        check("R11 last window nack", s_ack, 0);
        do_start(); do_byte({MEM, 1'b0});
        check("R11 awake ack", s_ack, 1);
        do_stop();
    endtask

    task automatic t_collide();
        logic [7:0] p;
        do_start(); do_byte({MEM, 1'b0}); do_byte(8'h50);
        byte_data = 8'h99; ev_byte = 1; sleep_req = 1;
        step(); ev_byte = 0; sleep_req = 0; capture();
        check("R12 collide nack", s_ack, 0); check("R12 no write", s_wr, 0);
        for (int k = 1; k <= SLP; k++) step();
        check("R12 asleep after", pwr_down, 1);
        do_start(); do_byte({MEM, 1'b0});
        for (int k = 0; k < WAK + 2; k++) step();
        read_ptr(MEM, p);
        check("R12 ptr unchanged", p, 8'h50);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        step();
        t_reset();
        t_write();
        t_wrap();
        t_cmd();
        t_wp();
        t_read();
        t_badaddr();
        t_busy();
        t_sleep();
        t_collide();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule